// File: doc/BRIEF.md
# Power Button Sleep-State Controller

This block keeps a simplified system power state, from S0 (running) to S5 (soft off), and turns two external inputs into power events. The active-low push button passes through a synchronizer and a tick-based debouncer. A clean press while the system sleeps wakes it. A press held long enough while it runs forces an unconditional power-down to S5, with no handshake from any other agent. A ring-indicator input can also wake the system when its enable is set. While the system runs, the ring indicator raises a one-cycle interrupt pulse instead.

Entry into the deep states S4 or S5 can open a minimum power-cycle window. For the length of that window nothing wakes the system and the hold timer stays idle. Once the window closes, a button that is still held wakes the system. The hold timer then begins again from zero in S0, so forcing an override takes a fresh full hold. All timing counts a prescaled tick input, so the parameters give lengths in ticks rather than in clock cycles.

Top module: `pwr_btn_ctrl`

## Requirements
- R1: Reset state: after a synchronous reset, `state_o` is 0 (S0), and `wake_o`, `ovr_o`, `irq_o` and `btn_level` are all 0.
- R2: The debounced level changes only after the synchronized input has differed from `btn_level` for DEB_TICKS consecutive ticks. A shorter glitch leaves `btn_level` unchanged. `btn_level` is 1 while the button is pressed, which is `btn_n` low.
- R3: In S0, a one-cycle `sleep_req` with `sleep_tgt` from 1 to 5 moves the state to that target. A target of 0, 6 or 7 is ignored, and so is any request made outside S0.
- R4: In S1 to S5 with no window running, a pressed and armed button gives a one-cycle `wake_o` and moves the state to S0.
- R5: The override works as follows. If `btn_level` stays 1 in S0 for HOLD_TICKS ticks, the block emits a one-cycle `ovr_o` and moves to S5. It fires at most once per continuous hold.
- R6: Releasing the button before the hold threshold clears the hold count. A later press needs a full HOLD_TICKS again.
- R7: The hold timer counts only in S0. A press held through a wake starts counting from zero on entry to S0.
- R8: When `stretch_en` is 1, entering S4 or S5 opens a window of STRETCH_TICKS ticks. During the window no button or ring wake happens. After it closes, a held button wakes the system.
- R9: After an override, the button must first be released (`btn_level` 0) before a press can wake the system.
- R10: A rising edge of `ring_in` in S1 to S5 wakes the system only when `ring_en` is 1. When `ring_en` is 0 the edge is ignored. The ring input is synchronized but not debounced.
- R11: A rising edge of `ring_in` in S0 gives a one-cycle `irq_o` whatever the value of `ring_en`, and it does not change the state.
- R12: `state_o` encodes S0 to S5 as the values 0 to 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaled timing tick, one cycle wide |
| btn_n | input | 1 | Raw power button, active low |
| ring_in | input | 1 | Ring indicator, active high, not debounced |
| ring_en | input | 1 | Allows ring wake from S1 to S5 |
| stretch_en | input | 1 | Enables the deep-sleep minimum window |
| sleep_req | input | 1 | One-cycle request to enter a sleep state |
| sleep_tgt | input | 3 | Target state for `sleep_req` (1 to 5) |
| state_o | output | 3 | Current power state, 0 to 5 |
| wake_o | output | 1 | One-cycle wake pulse |
| ovr_o | output | 1 | One-cycle override pulse |
| irq_o | output | 1 | One-cycle ring interrupt pulse in S0 |
| btn_level | output | 1 | Debounced button level, 1 means pressed |

## Verification
The bench builds the block with DEB_TICKS=3, HOLD_TICKS=12 and STRETCH_TICKS=10, and it drives a tick on every second clock. With these values a full override hold, a hold interrupted by a release, and a window that expires under a held button each take only tens of cycles. The short run can therefore check that a partial hold does not carry over across a release. It can also confirm that hold time spent in a suspend state is not counted after the wake.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [2:0] {
    PS_S0 = 3'd0,
    PS_S1 = 3'd1,
    PS_S2 = 3'd2,
    PS_S3 = 3'd3,
    PS_S4 = 3'd4,
    PS_S5 = 3'd5
  } pstate_t;

  localparam logic [2:0] DEEP_FIRST = 3'd4;
  localparam logic [2:0] LAST_STATE = 3'd5;
endpackage

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int DEB_TICKS = 8,
  localparam int CW = (DEB_TICKS > 1) ? $clog2(DEB_TICKS) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic btn_n,
  output logic level
);
  logic [1:0]    sync_q;
  logic [CW-1:0] cnt;
  logic          raw_press;

  assign raw_press = ~sync_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 2'b11;
      cnt    <= '0;
      level  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], btn_n};
      if (raw_press == level) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt == CW'(DEB_TICKS - 1)) begin
          level <= raw_press;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter int HOLD_TICKS = 64,
  localparam int HW = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic run,
  output logic fire
);
  logic [HW-1:0] cnt;
  logic          done;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      done <= 1'b0;
      fire <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (!run) begin
        cnt  <= '0;
        done <= 1'b0;
      end else if (tick && !done) begin
        if (cnt == HW'(HOLD_TICKS - 1)) begin
          fire <= 1'b1;
          done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/stretch_timer.sv
module stretch_timer #(
  parameter int STRETCH_TICKS = 32,
  localparam int SW = $clog2(STRETCH_TICKS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic start,
  output logic active
);
  logic [SW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= SW'(STRETCH_TICKS);
    end else if (tick && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign active = (cnt != '0);
endmodule

// File: rtl/pwr_btn_ctrl.sv
module pwr_btn_ctrl
  import pwr_pkg::*;
#(
  parameter int DEB_TICKS     = 8,
  parameter int HOLD_TICKS    = 64,
  parameter int STRETCH_TICKS = 32,
  parameter int RING_SYNC     = 2,
  localparam int RSW = RING_SYNC + 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       btn_n,
  input  logic       ring_in,
  input  logic       ring_en,
  input  logic       stretch_en,
  input  logic       sleep_req,
  input  logic [2:0] sleep_tgt,
  output logic [2:0] state_o,
  output logic       wake_o,
  output logic       ovr_o,
  output logic       irq_o,
  output logic       btn_level
);
  pstate_t        st;
  logic           pressed, armed;
  logic           hold_run, hold_fire;
  logic           stretch_act, stretch_go;
  logic [RSW-1:0] ring_sr;
  logic           ring_edge;
  logic           in_s0, tgt_ok, sleep_go, wake_go, ovr_go, irq_go;

  btn_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
    .clk(clk), .rst(rst), .tick(tick), .btn_n(btn_n), .level(pressed)
  );

  hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk(clk), .rst(rst), .tick(tick), .run(hold_run), .fire(hold_fire)
  );

  stretch_timer #(.STRETCH_TICKS(STRETCH_TICKS)) u_str (
    .clk(clk), .rst(rst), .tick(tick), .start(stretch_go), .active(stretch_act)
  );

  always_ff @(posedge clk) begin
    if (rst) ring_sr <= '0;
    else     ring_sr <= {ring_sr[RSW-2:0], ring_in};
  end
  assign ring_edge = ring_sr[RSW-2] & ~ring_sr[RSW-1];

  assign in_s0      = (st == PS_S0);
  assign tgt_ok     = (sleep_tgt != 3'd0) && (sleep_tgt <= LAST_STATE);
  assign ovr_go     = in_s0 & hold_fire;
  assign sleep_go   = in_s0 & sleep_req & tgt_ok & ~hold_fire;
  assign stretch_go = stretch_en & (ovr_go | (sleep_go & (sleep_tgt >= DEEP_FIRST)));
  assign wake_go    = ~in_s0 & ~stretch_act & ((pressed & armed) | (ring_edge & ring_en));
  assign hold_run   = in_s0 & pressed & ~stretch_act;
  assign irq_go     = in_s0 & ring_edge;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= PS_S0;
      armed  <= 1'b1;
      wake_o <= 1'b0;
      ovr_o  <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      wake_o <= wake_go;
      ovr_o  <= ovr_go;
      irq_o  <= irq_go;
      if (!pressed) armed <= 1'b1;
      if (ovr_go) begin
        st    <= PS_S5;
        armed <= 1'b0;
      end else if (sleep_go) begin
        st <= pstate_t'(sleep_tgt);
      end else if (wake_go) begin
        st <= PS_S0;
      end
    end
  end

  assign state_o   = st;
  assign btn_level = pressed;
endmodule

// File: rtl/pwr_btn_ctrl_chk.sv
module pwr_btn_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] state_o,
  input logic       wake_o,
  input logic       ovr_o,
  input logic       irq_o,
  input logic       btn_level,
  input logic       stretch_act
);
  // R4
  wake_lands_s0_chk: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> (state_o == 3'd0) && ($past(state_o) != 3'd0));
  // R5
  ovr_from_s0_chk: assert property (@(posedge clk) disable iff (rst)
    ovr_o |-> (state_o == 3'd5) && ($past(state_o) == 3'd0) && $past(btn_level));
  // R11
  irq_only_running_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ($past(state_o) == 3'd0));
  // R8
  no_wake_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    stretch_act |=> !wake_o);
  // R8
  window_deep_only_chk: assert property (@(posedge clk) disable iff (rst)
    stretch_act |-> (state_o >= 3'd4));
  // R12
  state_range_chk: assert property (@(posedge clk) disable iff (rst)
    state_o <= 3'd5);
endmodule

bind pwr_btn_ctrl pwr_btn_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .state_o(state_o), .wake_o(wake_o), .ovr_o(ovr_o),
  .irq_o(irq_o), .btn_level(btn_level), .stretch_act(stretch_act)
);

// File: tb/pwr_btn_ctrl_test.sv
module pwr_btn_ctrl_test;
  localparam int DEB = 3, HOLD = 12, STR = 10;
  localparam int EV_WAKE = 0, EV_OVR = 1, EV_IRQ = 2;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic btn_n = 1'b1, ring_in = 1'b0, ring_en = 1'b0, stretch_en = 1'b0;
  logic sleep_req = 1'b0;
  logic [2:0] sleep_tgt = 3'd0;
  logic [2:0] state_o;
  logic wake_o, ovr_o, irq_o, btn_level;
  int checks = 0, failures = 0;
  int exp_q[$];
  int exp_st[$];

  always #2.5 clk = ~clk;

  pwr_btn_ctrl #(.DEB_TICKS(DEB), .HOLD_TICKS(HOLD), .STRETCH_TICKS(STR)) uut (
    .clk(clk), .rst(rst), .tick(tick), .btn_n(btn_n), .ring_in(ring_in),
    .ring_en(ring_en), .stretch_en(stretch_en), .sleep_req(sleep_req),
    .sleep_tgt(sleep_tgt), .state_o(state_o), .wake_o(wake_o), .ovr_o(ovr_o),
    .irq_o(irq_o), .btn_level(btn_level)
  );

  always @(negedge clk) tick <= ~tick;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_ev(input int kind, input int st);
    exp_q.push_back(kind);
    exp_st.push_back(st);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && (wake_o || ovr_o || irq_o)) begin
      int kind;
      kind = wake_o ? EV_WAKE : (ovr_o ? EV_OVR : EV_IRQ);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4/R5/R11 unexpected event", kind, -1);
      end else begin
        int ek, es;
        ek = exp_q.pop_front();
        es = exp_st.pop_front();
        chk(kind == ek, "R4/R5/R11 event kind", kind, ek);
        chk(int'(state_o) == es, "R12 state after event", state_o, es);
      end
    end
  end

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic wait_level(input logic v);
    @(negedge clk);
    while (btn_level !== v) @(negedge clk);
  endtask

  task automatic wait_state(input int s);
    @(negedge clk);
    while (int'(state_o) != s) @(negedge clk);
  endtask

  task automatic sleep_to(input logic [2:0] t);
    @(negedge clk);
    sleep_req = 1'b1;
    sleep_tgt = t;
    @(negedge clk);
    sleep_req = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic ring_pulse();
    @(negedge clk);
    ring_in = 1'b1;
    repeat (4) @(negedge clk);
    ring_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    report();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 R12
    chk(state_o == 3'd0, "R1 reset state", state_o, 0);
    chk(!wake_o && !ovr_o && !irq_o, "R1 reset pulses", {wake_o, ovr_o, irq_o}, 0);
    chk(btn_level == 1'b0, "R1 reset level", btn_level, 0);

    // R2 short glitch ignored
    btn_n = 1'b0;
    repeat (2) @(negedge clk);
    btn_n = 1'b1;
    wait_ticks(6);
    chk(btn_level == 1'b0, "R2 glitch ignored", btn_level, 0);

    // R6 partial hold then release
    btn_n = 1'b0;
    wait_level(1'b1);
    chk(btn_level == 1'b1, "R2 stable press seen", btn_level, 1);
    wait_ticks(6);
    chk(state_o == 3'd0, "R6 partial hold no override", state_o, 0);
    btn_n = 1'b1;
    wait_level(1'b0);
    btn_n = 1'b0;
    wait_level(1'b1);
    push_ev(EV_OVR, 5);
    wait_ticks(8);
    chk(state_o == 3'd0, "R6 count cleared by release", state_o, 0);
    wait_ticks(6);
    chk(state_o == 3'd5, "R5 override to S5", state_o, 5);

    // R9 held after override: no wake
    wait_ticks(8);
    chk(state_o == 3'd5, "R9 no wake until release", state_o, 5);
    btn_n = 1'b1;
    wait_level(1'b0);
    push_ev(EV_WAKE, 0);
    btn_n = 1'b0;
    wait_level(1'b1);
    wait_ticks(2);
    chk(state_o == 3'd0, "R4 press wakes from S5", state_o, 0);
    btn_n = 1'b1;
    wait_level(1'b0);

    // R3 sleep requests
    sleep_to(3'd0);
    chk(state_o == 3'd0, "R3 target 0 ignored", state_o, 0);
    sleep_to(3'd7);
    chk(state_o == 3'd0, "R3 target 7 ignored", state_o, 0);
    sleep_to(3'd3);
    chk(state_o == 3'd3, "R3 R12 enter S3", state_o, 3);
    sleep_to(3'd5);
    chk(state_o == 3'd3, "R3 request outside S0 ignored", state_o, 3);

    // R10 ring gating
    ring_en = 1'b0;
    ring_pulse();
    chk(state_o == 3'd3, "R10 ring ignored when disabled", state_o, 3);
    ring_en = 1'b1;
    push_ev(EV_WAKE, 0);
    ring_pulse();
    chk(state_o == 3'd0, "R10 ring wakes when enabled", state_o, 0);

    // R11 ring in S0
    ring_en = 1'b0;
    push_ev(EV_IRQ, 0);
    ring_pulse();
    chk(state_o == 3'd0, "R11 ring interrupt keeps S0", state_o, 0);

    // R8 R7 window blocks wake, hold restarts in S0
    stretch_en = 1'b1;
    sleep_to(3'd5);
    btn_n = 1'b0;
    wait_level(1'b1);
    wait_ticks(1);
    chk(state_o == 3'd5, "R8 press blocked in window", state_o, 5);
    push_ev(EV_WAKE, 0);
    wait_state(0);
    wait_ticks(9);
    chk(state_o == 3'd0, "R7 hold not counted in suspend", state_o, 0);
    push_ev(EV_OVR, 5);
    wait_ticks(6);
    chk(state_o == 3'd5, "R5 override after fresh hold", state_o, 5);
    btn_n = 1'b1;
    wait_level(1'b0);
    wait_ticks(12);

    // R8 ring blocked in window
    ring_en = 1'b1;
    push_ev(EV_WAKE, 0);
    ring_pulse();
    chk(state_o == 3'd0, "R10 ring wake after window", state_o, 0);
    sleep_to(3'd4);
    ring_pulse();
    wait_ticks(3);
    chk(state_o == 3'd4, "R8 ring blocked in window", state_o, 4);
    wait_ticks(12);
    push_ev(EV_WAKE, 0);
    ring_pulse();
    wait_ticks(2);
    chk(state_o == 3'd0, "R8 ring wake after expiry", state_o, 0);

    wait_ticks(4);
    chk(exp_q.size() == 0, "R4/R5/R11 all expected events seen", exp_q.size(), 0);
    report();
    $finish;
  end
endmodule